// File: doc/BRIEF.md
# Relative Conditional Branch Resolver

This block is one pipeline stage that resolves a branch instruction whose target is relative to the branch's own address. On each cycle with the valid strobe high, it takes one 32-bit instruction word, the address of that instruction and the current 2-bit condition code. From the word it extracts a 4-bit condition mask and a signed 16-bit halfword offset. It then decides whether the branch is taken. The result, one cycle later, is the next instruction address. That address is either the relative target or the sequential address just past the 4-byte instruction.

Word layout, from the most significant bit down:
- bits [31:24]: primary opcode byte, expected value `OPCODE_VAL` (default 0xA7)
- bits [23:20]: mask
- bits [19:16]: opcode extension, expected value `EXT_VAL` (default 0x4)
- bits [15:0]: immediate

A word whose opcode or extension does not match is reported as illegal. Such a word never branches.

Top module: `brc_resolver`

## Requirements
- R1: While `rst` is high at a clock edge, all outputs are cleared after that edge: `out_valid`, `out_taken`, `out_illegal` are 0 and `out_next_addr` is 0.
- R2: `out_valid` equals the value `in_valid` had at the previous clock edge (one-cycle latency).
- R3: For a legal word, the branch is taken exactly when the mask bit chosen by `cc` is 1. Mask bit 3 selects code 00 (zero/equal), bit 2 selects 01 (low/minus), bit 1 selects 10 (high/plus), and bit 0 selects 11 (overflow).
- R4: Mask 0000 is never taken, for any code. Mask 1111 is always taken. Mask 1000 is taken only when the code is 00.
- R5: A taken branch yields `insn_addr + (sign-extended imm << 1)`. Examples: imm 0x7FFF gives +65534, imm 0x8000 gives -65536, and imm 0xFFFF gives the address 2 bytes before the branch.
- R6: When the branch is not taken, `out_next_addr` is `insn_addr + 4`.
- R7: Both the target and the fall-through address wrap modulo 2^32.
- R8: A word with opcode byte [31:24] not equal to 0xA7, or extension [19:16] not equal to 0x4, sets `out_illegal`. It clears `out_taken` and gives the fall-through address, whatever the mask and code are.
- R9: In a cycle with `in_valid` low, `out_taken`, `out_illegal` and `out_next_addr` keep their previous values, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction fields valid this cycle |
| insn | input | 32 | Instruction word |
| insn_addr | input | 32 | Byte address of the instruction |
| cc | input | 2 | Current condition code |
| out_valid | output | 1 | Result valid (registered) |
| out_taken | output | 1 | Branch taken |
| out_illegal | output | 1 | Opcode or extension mismatch |
| out_next_addr | output | 32 | Next instruction address |

## Verification
The assertions check on every cycle:
- the one-cycle valid latency;
- that outputs hold while no request is present;
- that an illegal word never branches and falls through;
- that the taken flag of a legal word follows the mask bit chosen by the code;
- that every not-taken result is the address plus four.

Only the bench's scenarios can show the exact target arithmetic. This covers the extreme forward and backward offsets, the minus-one halfword case and wraparound at the top of the address space. The bench also sweeps all 64 mask and code pairings against an independent model.

// File: rtl/brc_pkg.sv
package brc_pkg;
  localparam int INSN_W  = 32;
  localparam int IMM_W   = 16;
  localparam int MASK_W  = 4;
  localparam int CC_W    = 2;
  localparam int NUM_CC  = 1 << CC_W;

  typedef enum logic [CC_W-1:0] {
    CC_ZERO = 2'b00,
    CC_LOW  = 2'b01,
    CC_HIGH = 2'b10,
    CC_OVF  = 2'b11
  } cond_code_e;

  typedef struct packed {
    logic [7:0]        opcode;
    logic [MASK_W-1:0] mask;
    logic [3:0]        ext;
    logic [IMM_W-1:0]  imm;
  } brc_word_t;
endpackage

// File: rtl/brc_field_decode.sv
module brc_field_decode
  import brc_pkg::*;
#(
  parameter logic [7:0] OPCODE_VAL = 8'hA7,
  parameter logic [3:0] EXT_VAL    = 4'h4
) (
  input  logic [INSN_W-1:0] insn,
  output logic [MASK_W-1:0] mask,
  output logic [IMM_W-1:0]  imm,
  output logic              legal
);
  brc_word_t w;

  always_comb begin
    w     = brc_word_t'(insn);
    mask  = w.mask;
    imm   = w.imm;
    legal = (w.opcode == OPCODE_VAL) && (w.ext == EXT_VAL);
  end
endmodule

// File: rtl/brc_cond_eval.sv
module brc_cond_eval
  import brc_pkg::*;
(
  input  logic [MASK_W-1:0] mask,
  input  logic [CC_W-1:0]   cc,
  input  logic              legal,
  output logic              taken
);
  logic [NUM_CC-1:0] hit;

  // Code value i is selected by mask bit (NUM_CC-1-i): MSB pairs with code 0.
  for (genvar i = 0; i < NUM_CC; i++) begin : g_code
    assign hit[i] = mask[NUM_CC-1-i] && (cc == CC_W'(i));
  end

  assign taken = legal && (|hit);
endmodule

// File: rtl/brc_addr_gen.sv
module brc_addr_gen
  import brc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] insn_addr,
  input  logic [IMM_W-1:0]  imm,
  input  logic              taken,
  output logic [ADDR_W-1:0] next_addr
);
  localparam int INSN_BYTES = INSN_W / 8;
  localparam int EXT_BITS   = ADDR_W - IMM_W - 1;

  logic [ADDR_W-1:0] byte_off;
  logic [ADDR_W-1:0] target;
  logic [ADDR_W-1:0] seq;

  always_comb begin
    byte_off  = {{EXT_BITS{imm[IMM_W-1]}}, imm, 1'b0};
    target    = insn_addr + byte_off;
    seq       = insn_addr + ADDR_W'(INSN_BYTES);
    next_addr = taken ? target : seq;
  end
endmodule

// File: rtl/brc_resolver.sv
module brc_resolver
  import brc_pkg::*;
#(
  parameter int         ADDR_W     = 32,
  parameter logic [7:0] OPCODE_VAL = 8'hA7,
  parameter logic [3:0] EXT_VAL    = 4'h4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [31:0]       insn,
  input  logic [ADDR_W-1:0] insn_addr,
  input  logic [1:0]        cc,
  output logic              out_valid,
  output logic              out_taken,
  output logic              out_illegal,
  output logic [ADDR_W-1:0] out_next_addr
);
  logic [MASK_W-1:0] mask;
  logic [IMM_W-1:0]  imm;
  logic              legal;
  logic              taken_c;
  logic [ADDR_W-1:0] next_c;

  brc_field_decode #(.OPCODE_VAL(OPCODE_VAL), .EXT_VAL(EXT_VAL)) u_dec (
    .insn  (insn),
    .mask  (mask),
    .imm   (imm),
    .legal (legal)
  );

  brc_cond_eval u_cond (
    .mask  (mask),
    .cc    (cc),
    .legal (legal),
    .taken (taken_c)
  );

  brc_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .insn_addr (insn_addr),
    .imm       (imm),
    .taken     (taken_c),
    .next_addr (next_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid     <= 1'b0;
      out_taken     <= 1'b0;
      out_illegal   <= 1'b0;
      out_next_addr <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_taken     <= taken_c;
        out_illegal   <= !legal;
        out_next_addr <= next_c;
      end
    end
  end
endmodule

// File: rtl/brc_resolver_chk.sv
module brc_resolver_chk #(
  parameter int         ADDR_W     = 32,
  parameter logic [7:0] OPCODE_VAL = 8'hA7,
  parameter logic [3:0] EXT_VAL    = 4'h4
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [31:0]       insn,
  input logic [ADDR_W-1:0] insn_addr,
  input logic [1:0]        cc,
  input logic              out_valid,
  input logic              out_taken,
  input logic              out_illegal,
  input logic [ADDR_W-1:0] out_next_addr
);
  logic word_ok;
  logic sel_bit;

  always_comb begin
    word_ok = (insn[31:24] == OPCODE_VAL) && (insn[19:16] == EXT_VAL);
    case (cc)
      2'd0:    sel_bit = insn[23];
      2'd1:    sel_bit = insn[22];
      2'd2:    sel_bit = insn[21];
      default: sel_bit = insn[20];
    endcase
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_taken && !out_illegal));

  p_valid_lat_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_valid_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  p_mask_select_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && word_ok) |=> (out_taken == $past(sel_bit)));

  p_fallthrough_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !(word_ok && sel_bit)) |=>
      (out_next_addr == $past(insn_addr) + ADDR_W'(4)));

  p_illegal_safe_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_illegal) |-> !out_taken);

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_next_addr) && $stable(out_taken) && $stable(out_illegal)));
endmodule

bind brc_resolver brc_resolver_chk #(
  .ADDR_W(ADDR_W), .OPCODE_VAL(OPCODE_VAL), .EXT_VAL(EXT_VAL)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .in_valid      (in_valid),
  .insn          (insn),
  .insn_addr     (insn_addr),
  .cc            (cc),
  .out_valid     (out_valid),
  .out_taken     (out_taken),
  .out_illegal   (out_illegal),
  .out_next_addr (out_next_addr)
);

// File: tb/brc_resolver_tb.sv
`timescale 1ns/1ps
module brc_resolver_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] insn = '0;
  logic [31:0] insn_addr = '0;
  logic [1:0]  cc = '0;
  logic        out_valid, out_taken, out_illegal;
  logic [31:0] out_next_addr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic        e_valid = 1'b0, e_taken = 1'b0, e_illegal = 1'b0;
  logic [31:0] e_next = '0;

  always #2 clk = ~clk;

  brc_resolver u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn),
    .insn_addr(insn_addr), .cc(cc), .out_valid(out_valid),
    .out_taken(out_taken), .out_illegal(out_illegal),
    .out_next_addr(out_next_addr)
  );

  function automatic logic [31:0] mk(input logic [3:0] m, input logic [15:0] i);
    return {8'hA7, m, 4'h4, i};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input logic v, input logic [31:0] w, input logic [31:0] a,
                     input logic [1:0] c, input logic r, input string req);
    logic ok, hit;
    int off;
    in_valid = v; insn = w; insn_addr = a; cc = c; rst = r;
    @(posedge clk); #1;
    if (r) begin
      e_valid = 0; e_taken = 0; e_illegal = 0; e_next = 0;
    end else begin
      e_valid = v;
      if (v) begin
        ok = (w[31:24] == 8'hA7) && (w[19:16] == 4'h4);
        case (c)
          2'b00: hit = w[23];
          2'b01: hit = w[22];
          2'b10: hit = w[21];
          2'b11: hit = w[20];
        endcase
        off = int'($signed(w[15:0])) * 2;
        e_illegal = !ok;
        e_taken = ok && hit;
        e_next = e_taken ? a + 32'(off) : a + 32'd4;
      end
    end
    chk(req, "valid", {31'b0, out_valid}, {31'b0, e_valid});
    chk(req, "taken", {31'b0, out_taken}, {31'b0, e_taken});
    chk(req, "illegal", {31'b0, out_illegal}, {31'b0, e_illegal});
    chk(req, "next", out_next_addr, e_next);
  endtask

  initial begin
    #400000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #1;
    // R1: reset state
    cyc(1, mk(4'hF, 16'h0010), 32'h1000, 2'd0, 1, "R1");
    cyc(1, mk(4'hF, 16'h0010), 32'h1000, 2'd0, 1, "R1");
    cyc(0, '0, '0, 2'd0, 0, "R2");
    // R3 R6: all mask/code pairings
    for (int m = 0; m < 16; m++)
      for (int c = 0; c < 4; c++)
        cyc(1, mk(4'(m), 16'h0040), 32'h0000_2000 + 32'(m * 16), 2'(c), 0, "R3");
    // R4
    for (int c = 0; c < 4; c++) cyc(1, mk(4'b0000, 16'h0100), 32'h3000, 2'(c), 0, "R4");
    for (int c = 0; c < 4; c++) cyc(1, mk(4'b1111, 16'h0100), 32'h3000, 2'(c), 0, "R4");
    for (int c = 0; c < 4; c++) cyc(1, mk(4'b1000, 16'h0100), 32'h3000, 2'(c), 0, "R4");
    // R5 reach
    cyc(1, mk(4'hF, 16'h7FFF), 32'h0010_0000, 2'd1, 0, "R5");
    chk("R5", "max forward", out_next_addr, 32'h0010_0000 + 32'd65534);
    cyc(1, mk(4'hF, 16'h8000), 32'h0010_0000, 2'd2, 0, "R5");
    chk("R5", "max backward", out_next_addr, 32'h0010_0000 - 32'd65536);
    cyc(1, mk(4'hF, 16'hFFFF), 32'h0000_4000, 2'd3, 0, "R5");
    chk("R5", "minus one", out_next_addr, 32'h0000_3FFE);
    // R6 fall-through
    cyc(1, mk(4'b0111, 16'h1234), 32'h0000_5000, 2'd0, 0, "R6");
    chk("R6", "fallthrough", out_next_addr, 32'h0000_5004);
    // R7 wrap
    cyc(1, mk(4'h0, 16'h0000), 32'hFFFF_FFFC, 2'd0, 0, "R7");
    chk("R7", "seq wrap", out_next_addr, 32'h0000_0000);
    cyc(1, mk(4'hF, 16'h0010), 32'hFFFF_FFF0, 2'd0, 0, "R7");
    chk("R7", "fwd wrap", out_next_addr, 32'h0000_0010);
    cyc(1, mk(4'hF, 16'hFFF0), 32'h0000_0008, 2'd0, 0, "R7");
    chk("R7", "back wrap", out_next_addr, 32'hFFFF_FFE8);
    // R8 illegal words
    cyc(1, {8'hA6, 4'hF, 4'h4, 16'h0020}, 32'h6000, 2'd0, 0, "R8");
    chk("R8", "bad opcode", {31'b0, out_illegal}, 32'd1);
    cyc(1, {8'hA7, 4'hF, 4'h5, 16'h0020}, 32'h6000, 2'd3, 0, "R8");
    chk("R8", "bad ext next", out_next_addr, 32'h6004);
    cyc(1, {8'h00, 4'hF, 4'h0, 16'hFFFF}, 32'h7000, 2'd1, 0, "R8");
    // R9 hold with garbage
    cyc(1, mk(4'hF, 16'h0100), 32'h8000, 2'd0, 0, "R9");
    for (int k = 0; k < 5; k++)
      cyc(0, 32'hDEAD_BEEF + 32'(k), 32'h1111_0000 * 32'(k + 1), 2'(k), 0, "R9");
    chk("R9", "held next", out_next_addr, 32'h8200);
    // R2 back-to-back and gaps
    for (int k = 0; k < 10; k++)
      cyc(k % 3 != 0, mk(4'(k), 16'(k * 7)), 32'h9000 + 32'(k * 4), 2'(k), 0, "R2");
    // R1 reset in mid-stream
    cyc(1, mk(4'hF, 16'h0004), 32'hA000, 2'd0, 1, "R1");
    cyc(0, '0, '0, 2'd0, 0, "R2");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule